// File: doc/BRIEF.md
# Debug Event Status Register

This block is a 32-bit status word that records which processor debug events have happened and what kind of reset came last. Each event source delivers a one-cycle pulse, and the pulse leaves a sticky flag in the word. One more flag records whether any captured event arrived while debug was disabled, which marks that event as imprecise. A two-bit field keeps the code of the most recent reset. That field is loaded from a reset-kind input whenever a reset strobe fires.

Software reads the whole word at any time through a combinational read port, and a read has no side effects. A write does not store its data. Its data is a clear mask: every 1 clears the matching status bit, and every 0 leaves that bit unchanged. Bits are numbered from 0 at the most significant end of the word, so status bit n appears on `rd_data[31-n]`.

Top module: `dbg_evt_status`

## Requirements
- R1: Layout, with bit 0 as the MSB. The imprecise flag is bit 0 (`rd_data[31]`). The unconditional event is bit 1 (`rd_data[30]`). The reset code sits in bits 2:3 (`rd_data[29:28]`), with bit 2 as the code's high bit. Instruction completion is bit 4 (`rd_data[27]`) and branch taken is bit 5 (`rd_data[26]`).
- R2: An event pulse sets its bit on the next clock edge. The bit then stays at 1 until it is cleared.
- R3: When a write is enabled, each status bit whose mask position is 1 reads 0 after the edge. Every bit whose mask position is 0 keeps its value.
- R4: If an event pulse and a mask clear of the same bit fall in one cycle, the bit ends up at 1.
- R5: If any event pulses while `dbg_en` is 0, the imprecise flag is set. Events that pulse while `dbg_en` is 1 do not set it.
- R6: A reset strobe clears all event bits and the imprecise flag. In the same edge it loads the reset code from `rst_kind` (01 core, 10 chip, 11 system). The strobe takes priority over events and writes in the same cycle.
- R7: The mask clears the reset-code bits one at a time. Once both bits are cleared the field reads 00, which means no reset since software last cleared it. Without a strobe or a write, the field holds its value.
- R8: Bits 6 to 31 of the numbering (`rd_data[25:0]`) always read 0, and writing a mask to them has no effect.
- R9: A read returns the current value in the same cycle. When there are no events, no writes and no strobe, the value stays constant.
- R10: While `rst_n` is low, every bit is cleared to 0 on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears the whole word |
| dbg_en | input | 1 | Debug enable level used to classify events |
| evt_uncond | input | 1 | Unconditional debug event pulse |
| evt_icomp | input | 1 | Instruction completion event pulse |
| evt_branch | input | 1 | Branch taken event pulse |
| rst_stb | input | 1 | One-cycle strobe: a processor reset occurred |
| rst_kind | input | 2 | Code of the reset that the strobe reports |
| wr_en | input | 1 | Software write enable |
| wr_mask | input | 32 | Clear mask, 1 clears the matching bit |
| rd_data | output | 32 | Current status word |

## Verification
The hardest cases to create are the three-way collisions in one cycle: an event pulse together with a mask clear of the same bit, and a reset strobe together with an event or a full-word clear. Each of these collisions needs all of those inputs raised on the same edge. The stimulus table sets every input of a step together, so each such row places the colliding inputs on one edge. The rows that follow then show that the right side won.

// File: rtl/dbg_evt_pkg.sv
// Package: shared constants for the debug event status register.
// Assumes status bits are numbered from 0 at the most significant end.
package dbg_evt_pkg;
    localparam int WORD_W  = 32;
    localparam int NUM_EVT = 3;

    // Status bit positions in MSB-0 numbering
    localparam int POS_IDE    = 0;
    localparam int POS_UDE    = 1;
    localparam int POS_MRR_HI = 2;
    localparam int POS_MRR_LO = 3;
    localparam int POS_ICMP   = 4;
    localparam int POS_BRT    = 5;

    // Event index to status position: 0 unconditional, 1 completion, 2 branch
    localparam int EVT_POS [NUM_EVT] = '{POS_UDE, POS_ICMP, POS_BRT};

    typedef enum logic [1:0] {
        RST_NONE = 2'b00,
        RST_CORE = 2'b01,
        RST_CHIP = 2'b10,
        RST_SYS  = 2'b11
    } rst_kind_e;

    // Convert an MSB-0 position to a vector index
    function automatic int msb0_idx(input int pos);
        return WORD_W - 1 - pos;
    endfunction
endpackage

// File: rtl/dbg_sticky_bit.sv
// Module: one sticky status flag.
// A set pulse raises it and a clear lowers it; set beats clear, flush beats both.
// Assumes all inputs are synchronous to clk.
module dbg_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Flag update with priority reset, flush, set, clear
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (flush) q <= 1'b0;
        else if (set)   q <= 1'b1;
        else if (clr)   q <= 1'b0;
    end
endmodule

// File: rtl/dbg_rst_field.sv
// Module: most-recent-reset code field.
// A strobe loads the code; a clear mask zeroes individual bits.
// Assumes load and mask arrive in the same clock domain.
module dbg_rst_field
    import dbg_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] code,
    input  logic [1:0] clr_mask,
    output logic [1:0] q
);
    rst_kind_e kind_q;

    // Field update: load has priority over the clear mask
    always_ff @(posedge clk) begin
        if (!rst_n)     kind_q <= RST_NONE;
        else if (load)  kind_q <= rst_kind_e'(code);
        else            kind_q <= rst_kind_e'(kind_q & ~clr_mask);
    end

    // Drive the raw code out
    assign q = kind_q;
endmodule

// File: rtl/dbg_evt_status.sv
// Module: debug event status register, top level.
// Captures event pulses as sticky bits, flags events seen with debug
// disabled as imprecise, records the last reset kind, and clears by mask.
// Assumes event pulses last one cycle; reads are combinational.
module dbg_evt_status
    import dbg_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_en,
    input  logic              evt_uncond,
    input  logic              evt_icomp,
    input  logic              evt_branch,
    input  logic              rst_stb,
    input  logic [1:0]        rst_kind,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_mask,
    output logic [WORD_W-1:0] rd_data
);
    localparam int IDX_IDE    = msb0_idx(POS_IDE);
    localparam int IDX_MRR_HI = msb0_idx(POS_MRR_HI);
    localparam int IDX_MRR_LO = msb0_idx(POS_MRR_LO);

    logic [NUM_EVT-1:0] evt_vec;
    logic [NUM_EVT-1:0] evt_q;
    logic [WORD_W-1:0]  clr_vec;
    logic               imprecise_hit;
    logic               ide_q;
    logic [1:0]         mrr_q;

    // Gather event pulses and gate the clear mask by the write enable
    always_comb begin
        evt_vec       = {evt_branch, evt_icomp, evt_uncond};
        clr_vec       = wr_en ? wr_mask : '0;
        imprecise_hit = (|evt_vec) & ~dbg_en;
    end

    // One sticky cell per event type
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        localparam int IDX = msb0_idx(EVT_POS[g]);
        dbg_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (rst_stb),
            .set   (evt_vec[g]),
            .clr   (clr_vec[IDX]),
            .q     (evt_q[g])
        );
    end

    dbg_sticky_bit u_ide (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rst_stb),
        .set   (imprecise_hit),
        .clr   (clr_vec[IDX_IDE]),
        .q     (ide_q)
    );

    dbg_rst_field u_mrr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rst_stb),
        .code     (rst_kind),
        .clr_mask ({clr_vec[IDX_MRR_HI], clr_vec[IDX_MRR_LO]}),
        .q        (mrr_q)
    );

    // Assemble the read word; unused positions stay 0
    always_comb begin
        rd_data             = '0;
        rd_data[IDX_IDE]    = ide_q;
        rd_data[IDX_MRR_HI] = mrr_q[1];
        rd_data[IDX_MRR_LO] = mrr_q[0];
        for (int i = 0; i < NUM_EVT; i++)
            rd_data[msb0_idx(EVT_POS[i])] = evt_q[i];
    end
endmodule

// File: rtl/dbg_evt_status_chk.sv
// Module: property checker for the debug event status register.
// Observes ports only; attached to the top by bind below.
module dbg_evt_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dbg_en,
    input logic        evt_uncond,
    input logic        evt_icomp,
    input logic        evt_branch,
    input logic        rst_stb,
    input logic [1:0]  rst_kind,
    input logic        wr_en,
    input logic [31:0] wr_mask,
    input logic [31:0] rd_data
);
    p_uncond_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_uncond && !rst_stb |=> rd_data[30]);
    p_icomp_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_icomp && !rst_stb |=> rd_data[27]);
    p_branch_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_branch && !rst_stb |=> rd_data[26]);
    p_mask_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_mask[26] && !evt_branch && !rst_stb |=> !rd_data[26]);
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_uncond && wr_en && wr_mask[30] && !rst_stb |=> rd_data[30]);
    p_imprecise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_uncond || evt_icomp || evt_branch) && !dbg_en && !rst_stb |=> rd_data[31]);
    p_precise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[31] && !((evt_uncond || evt_icomp || evt_branch) && !dbg_en) |=> !rd_data[31]);
    p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_stb |=> rd_data[31:26] == {2'b00, $past(rst_kind), 2'b00});
    p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_stb && !wr_en |=> $stable(rd_data[29:28]));
    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_stb && !wr_en && !evt_uncond && !evt_icomp && !evt_branch |=> $stable(rd_data));
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> rd_data == 32'h0);
endmodule

bind dbg_evt_status dbg_evt_status_chk u_chk (.*);

// File: tb/dbg_evt_status_bench.sv
`timescale 1ns/1ps
module dbg_evt_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_en = 1'b1;
    logic        evt_uncond = 1'b0, evt_icomp = 1'b0, evt_branch = 1'b0;
    logic        rst_stb = 1'b0;
    logic [1:0]  rst_kind = 2'b00;
    logic        wr_en = 1'b0;
    logic [31:0] wr_mask = '0;
    logic [31:0] rd_data;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    dbg_evt_status u_dbg_evt_status (.*);

    typedef struct packed {
        logic [2:0]  evt;   // {branch, icomp, uncond}
        logic        en;
        logic        wr;
        logic [31:0] mask;
        logic        stb;
        logic [1:0]  kind;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{3'b001, 1'b1, 1'b0, 32'h0,         1'b0, 2'b00, 32'h4000_0000, 8'd2}, // R2 R1 uncond
        '{3'b010, 1'b0, 1'b0, 32'h0,         1'b0, 2'b00, 32'hC800_0000, 8'd5}, // R5 imprecise
        '{3'b100, 1'b1, 1'b0, 32'h0,         1'b0, 2'b00, 32'hCC00_0000, 8'd2}, // R2 branch
        '{3'b000, 1'b1, 1'b1, 32'h0800_0000, 1'b0, 2'b00, 32'hC400_0000, 8'd3}, // R3 one bit
        '{3'b100, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 2'b00, 32'h0400_0000, 8'd4}, // R4 set wins
        '{3'b001, 1'b1, 1'b0, 32'h0,         1'b1, 2'b01, 32'h1000_0000, 8'd6}, // R6 core, beats event
        '{3'b001, 1'b0, 1'b0, 32'h0,         1'b0, 2'b00, 32'hD000_0000, 8'd5}, // R5
        '{3'b000, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 2'b10, 32'h2000_0000, 8'd6}, // R6 chip, beats write
        '{3'b000, 1'b1, 1'b0, 32'h0,         1'b1, 2'b11, 32'h3000_0000, 8'd6}, // R6 system
        '{3'b000, 1'b1, 1'b1, 32'h2000_0000, 1'b0, 2'b00, 32'h1000_0000, 8'd7}, // R7 high bit
        '{3'b000, 1'b1, 1'b1, 32'h1000_0000, 1'b0, 2'b00, 32'h0000_0000, 8'd7}, // R7 to none
        '{3'b111, 1'b1, 1'b1, 32'h0,         1'b0, 2'b00, 32'h4C00_0000, 8'd3}, // R3 zero mask
        '{3'b000, 1'b1, 1'b1, 32'h03FF_FFFF, 1'b0, 2'b00, 32'h4C00_0000, 8'd8}, // R8 reserved
        '{3'b111, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 2'b00, 32'hCC00_0000, 8'd4}  // R4 flag set wins
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check(10, rd_data, 32'h0);            // R10 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            {evt_branch, evt_icomp, evt_uncond} = TBL[i].evt;
            dbg_en = TBL[i].en; wr_en = TBL[i].wr; wr_mask = TBL[i].mask;
            rst_stb = TBL[i].stb; rst_kind = TBL[i].kind;
            @(posedge clk); #1;
            {evt_branch, evt_icomp, evt_uncond} = 3'b000;
            wr_en = 1'b0; wr_mask = '0; rst_stb = 1'b0; dbg_en = 1'b1;
            check(TBL[i].req, rd_data, TBL[i].exp);
        end
        // R9: combinational read, idle hold
        repeat (4) @(posedge clk);
        #1 check(9, rd_data, 32'hCC00_0000);
        // R1: unconditional alone lands on rd_data[30]
        wr_en = 1'b1; wr_mask = 32'hFFFF_FFFF;
        @(posedge clk); #1 wr_en = 1'b0;
        check(3, rd_data, 32'h0);                 // R3 full clear
        evt_uncond = 1'b1;
        @(posedge clk); #1 evt_uncond = 1'b0;
        check(1, rd_data, 32'h4000_0000);         // R1 position
        // R10: active-low reset mid-run clears even the code field
        rst_stb = 1'b1; rst_kind = 2'b11;
        @(posedge clk); #1 rst_stb = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); #1 check(10, rd_data, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #1 check(10, rd_data, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule